// File: doc/BRIEF.md
# Five-Stage In-Order Processor Core

This block is a small 32-bit in-order processor that overlaps five instruction phases: fetch, decode, execute, memory access and writeback. Four pipeline registers separate the phases. A new instruction enters every clock, and each instruction leaves writeback four cycles after it was fetched. The core runs load word, store word, add, subtract, bitwise and, bitwise or, and branch-if-equal. Instructions come from an internal read-only program store that is set by a parameter. Data lives in an internal word RAM.

Control is decoded once, in the decode phase. It is split into three groups: execute controls, memory controls and writeback controls. Each group travels in the pipeline registers together with the operands and the destination index, and is dropped after the phase that consumes it. The core has no interlocks and no operand forwarding. Programs must therefore keep a consumer at least three instruction slots behind its producer, filling the gap with no-ops where needed. The result of each writeback and each store is shown on observation ports.

Top module: `pipe5_core`

## Requirements
- R1: On synchronous reset the program counter is 0. Every pipeline register is cleared to a bubble with all control bits zero, so no register write and no store appears while the pipeline fills. Register k (k>0) resets to REG_BASE+k and data word i resets to MEM_BASE+i.
- R2: One 32-bit word is fetched per cycle, and without a taken branch the program counter advances by 4 each cycle. The instruction fetched in cycle c writes back in cycle c+4.
- R3: An instruction whose bits 31:26 are 0 and whose bits 5:0 are 32 (add), 34 (sub), 36 (and) or 37 (or) combines the register named by bits 25:21 with the register named by bits 20:16. It writes the result to the register named by bits 15:11, shown on the writeback port in cycle c+4.
- R4: Opcode 35 loads the data word at byte address reg[25:21] + imm into the register named by bits 20:16, with the result due in cycle c+4. Opcode 43 stores reg[20:16] to that address, shown on the store port in cycle c+3. The word index is the address bits above bit 1.
- R5: The immediate is bits 15:0, sign-extended to 32 bits, so a negative offset lowers the address.
- R6: A register written in writeback is seen by a decode-phase read of the same register in the same cycle.
- R7: Register 0 always reads as zero, and writes to it have no effect.
- R8: Opcode 4 compares reg[25:21] with reg[20:16] by subtraction. If they are equal, the branch resolves in the memory phase and sets the program counter to (address+4) + (imm << 2), which is fetched in cycle c+4. The three instructions fetched after the branch produce no register write and no store.
- R9: A branch whose operands differ does not change the sequential fetch order.
- R10: An all-zero word, and any word with an unlisted opcode or function code, produces no register write and no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | output | 32 | Address being fetched this cycle |
| wb_we | output | 1 | A register write to a nonzero register commits this cycle |
| wb_reg | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value written |
| st_we | output | 1 | A store is performed this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Stored word |

## Verification
Each instruction result has a fixed due cycle, counted from reset release with the first fetch as cycle 0. A register write from the instruction fetched in cycle c is due on the writeback port in cycle c+4. A store is due on the store port in cycle c+3. After a taken branch that was fetched in cycle c, the new target appears on fetch_pc in cycle c+4. The bench queues every expected item together with its due cycle and samples the ports at mid-cycle. An item that arrives early, arrives late, is missing, or is not in the queue at all counts as a failure. This is how squashed instructions and writes to register 0 are caught at the ports.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN    = 32;
    localparam int REG_IDX = 5;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_op_e;

    // control consumed in execute
    typedef struct packed {
        logic    use_imm;
        alu_op_e op;
        logic    dst_is_rd;
    } ex_ctl_t;

    // control consumed in memory
    typedef struct packed {
        logic rd_en;
        logic wr_en;
        logic is_branch;
    } mem_ctl_t;

    // control consumed in writeback
    typedef struct packed {
        logic reg_wr;
        logic from_mem;
    } wb_ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] word;
    } fd_reg_t;

    typedef struct packed {
        ex_ctl_t            ex;
        mem_ctl_t           mem;
        wb_ctl_t            wb;
        logic [XLEN-1:0]    pc4;
        logic [XLEN-1:0]    src_a;
        logic [XLEN-1:0]    src_b;
        logic [XLEN-1:0]    imm;
        logic [REG_IDX-1:0] rt_idx;
        logic [REG_IDX-1:0] rd_idx;
    } dx_reg_t;

    typedef struct packed {
        mem_ctl_t           mem;
        wb_ctl_t            wb;
        logic [XLEN-1:0]    target;
        logic               zero;
        logic [XLEN-1:0]    result;
        logic [XLEN-1:0]    st_val;
        logic [REG_IDX-1:0] dst;
    } xm_reg_t;

    typedef struct packed {
        wb_ctl_t            wb;
        logic [XLEN-1:0]    result;
        logic [XLEN-1:0]    ld_val;
        logic [REG_IDX-1:0] dst;
    } mw_reg_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [5:0] opc_of(input logic [XLEN-1:0] w);
        return w[31:26];
    endfunction

endpackage

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl
    import pipe5_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ex_ctl_t    ex_o,
    output mem_ctl_t   mem_o,
    output wb_ctl_t    wb_o
);

    always_comb begin
        ex_o  = '0;
        mem_o = '0;
        wb_o  = '0;
        unique case (opcode)
            OPC_RTYPE: begin
                if (funct == FN_ADD || funct == FN_SUB ||
                    funct == FN_AND || funct == FN_OR) begin
                    ex_o.dst_is_rd = 1'b1;
                    wb_o.reg_wr    = 1'b1;
                    case (funct)
                        FN_SUB:  ex_o.op = ALU_SUB;
                        FN_AND:  ex_o.op = ALU_AND;
                        FN_OR:   ex_o.op = ALU_OR;
                        default: ex_o.op = ALU_ADD;
                    endcase
                end
            end
            OPC_LOAD: begin
                ex_o.use_imm = 1'b1;
                ex_o.op      = ALU_ADD;
                mem_o.rd_en  = 1'b1;
                wb_o.reg_wr  = 1'b1;
                wb_o.from_mem = 1'b1;
            end
            OPC_STORE: begin
                ex_o.use_imm = 1'b1;
                ex_o.op      = ALU_ADD;
                mem_o.wr_en  = 1'b1;
            end
            OPC_BEQ: begin
                ex_o.op         = ALU_SUB;
                mem_o.is_branch = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
    import pipe5_pkg::*;
#(
    parameter int NREGS    = 32,
    parameter int REG_BASE = 100
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [REG_IDX-1:0]     ra_idx,
    input  logic [REG_IDX-1:0]     rb_idx,
    output logic [XLEN-1:0]        ra_val,
    output logic [XLEN-1:0]        rb_val,
    input  logic                   wr_en,
    input  logic [REG_IDX-1:0]     wr_idx,
    input  logic [XLEN-1:0]        wr_val
);

    logic [XLEN-1:0] regs [NREGS];
    logic            wr_live;

    assign wr_live = wr_en && (wr_idx != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREGS; k++) begin
                regs[k] <= (k == 0) ? '0 : XLEN'(REG_BASE + k);
            end
        end else if (wr_live) begin
            regs[wr_idx] <= wr_val;
        end
    end

    // write-before-read within the cycle; index 0 is hardwired
    always_comb begin
        if (ra_idx == '0)                     ra_val = '0;
        else if (wr_live && wr_idx == ra_idx) ra_val = wr_val;
        else                                  ra_val = regs[ra_idx];
        if (rb_idx == '0)                     rb_val = '0;
        else if (wr_live && wr_idx == rb_idx) rb_val = wr_val;
        else                                  rb_val = regs[rb_idx];
    end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/pipe5_dmem.sv
module pipe5_dmem
    import pipe5_pkg::*;
#(
    parameter int WORDS    = 64,
    parameter int MEM_BASE = 500
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] addr,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_val,
    output logic [XLEN-1:0] rd_val
);

    localparam int AW = $clog2(WORDS);

    logic [XLEN-1:0] mem [WORDS];
    logic [AW-1:0]   widx;
    logic            unused_addr_bits;

    assign widx             = addr[AW+1:2];
    assign unused_addr_bits = ^{addr[XLEN-1:AW+2], addr[1:0]};
    assign rd_val           = mem[widx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= XLEN'(MEM_BASE + i);
            end
        end else if (wr_en) begin
            mem[widx] <= wr_val;
        end
    end

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_WORDS = 32,
    parameter int DMEM_WORDS = 64,
    parameter int NREGS      = 32,
    parameter int REG_BASE   = 100,
    parameter int MEM_BASE   = 500,
    parameter logic [IMEM_WORDS*XLEN-1:0] PROGRAM = '0
) (
    input  logic                clk,
    input  logic                rst,
    output logic [XLEN-1:0]     fetch_pc,
    output logic                wb_we,
    output logic [REG_IDX-1:0]  wb_reg,
    output logic [XLEN-1:0]     wb_data,
    output logic                st_we,
    output logic [XLEN-1:0]     st_addr,
    output logic [XLEN-1:0]     st_data
);

    localparam int IA = $clog2(IMEM_WORDS);

    logic [XLEN-1:0] pc, pc_plus4, fetch_word;
    fd_reg_t fd_q;
    dx_reg_t dx_q, dx_d;
    xm_reg_t xm_q, xm_d;
    mw_reg_t mw_q, mw_d;

    logic                unused_pc_bits;
    logic [IA-1:0]       pc_word;
    logic [REG_IDX-1:0]  rs_addr, rt_addr;
    logic [XLEN-1:0]     rs_data, rt_data;
    ex_ctl_t             dec_ex;
    mem_ctl_t            dec_mem;
    wb_ctl_t             dec_wb;
    logic [XLEN-1:0]     alu_b, alu_y;
    logic                alu_zero;
    logic                br_take;
    logic [XLEN-1:0]     br_target;
    logic [XLEN-1:0]     ld_data;
    logic [XLEN-1:0]     wb_val;

    // ---------------- fetch ----------------
    assign pc_word        = pc[IA+1:2];
    assign unused_pc_bits = ^{pc[XLEN-1:IA+2], pc[1:0]};
    assign fetch_word     = PROGRAM[pc_word*XLEN +: XLEN];
    assign pc_plus4       = pc + XLEN'(4);

    // ---------------- decode ----------------
    assign rs_addr = fd_q.word[25:21];
    assign rt_addr = fd_q.word[20:16];

    pipe5_ctrl u_ctrl (
        .opcode (opc_of(fd_q.word)),
        .funct  (fd_q.word[5:0]),
        .ex_o   (dec_ex),
        .mem_o  (dec_mem),
        .wb_o   (dec_wb)
    );

    pipe5_regfile #(
        .NREGS    (NREGS),
        .REG_BASE (REG_BASE)
    ) u_rf (
        .clk    (clk),
        .rst    (rst),
        .ra_idx (rs_addr),
        .rb_idx (rt_addr),
        .ra_val (rs_data),
        .rb_val (rt_data),
        .wr_en  (mw_q.wb.reg_wr),
        .wr_idx (mw_q.dst),
        .wr_val (wb_val)
    );

    always_comb begin
        dx_d.ex     = dec_ex;
        dx_d.mem    = dec_mem;
        dx_d.wb     = dec_wb;
        dx_d.pc4    = fd_q.pc4;
        dx_d.src_a  = rs_data;
        dx_d.src_b  = rt_data;
        dx_d.imm    = sext16(fd_q.word[15:0]);
        dx_d.rt_idx = rt_addr;
        dx_d.rd_idx = fd_q.word[15:11];
    end

    // ---------------- execute ----------------
    assign alu_b = dx_q.ex.use_imm ? dx_q.imm : dx_q.src_b;

    pipe5_alu u_alu (
        .a    (dx_q.src_a),
        .b    (alu_b),
        .op   (dx_q.ex.op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        xm_d.mem    = dx_q.mem;
        xm_d.wb     = dx_q.wb;
        xm_d.target = dx_q.pc4 + {dx_q.imm[XLEN-3:0], 2'b00};
        xm_d.zero   = alu_zero;
        xm_d.result = alu_y;
        xm_d.st_val = dx_q.src_b;
        xm_d.dst    = dx_q.ex.dst_is_rd ? dx_q.rd_idx : dx_q.rt_idx;
    end

    // ---------------- memory ----------------
    assign br_take   = xm_q.mem.is_branch && xm_q.zero;
    assign br_target = xm_q.target;

    pipe5_dmem #(
        .WORDS    (DMEM_WORDS),
        .MEM_BASE (MEM_BASE)
    ) u_dmem (
        .clk    (clk),
        .rst    (rst),
        .addr   (xm_q.result),
        .wr_en  (xm_q.mem.wr_en),
        .wr_val (xm_q.st_val),
        .rd_val (ld_data)
    );

    always_comb begin
        mw_d.wb     = xm_q.wb;
        mw_d.result = xm_q.result;
        mw_d.ld_val = xm_q.mem.rd_en ? ld_data : '0;
        mw_d.dst    = xm_q.dst;
    end

    // ---------------- writeback ----------------
    assign wb_val = mw_q.wb.from_mem ? mw_q.ld_val : mw_q.result;

    // ---------------- pipeline registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= '0;
            fd_q <= '0;
            dx_q <= '0;
            xm_q <= '0;
            mw_q <= '0;
        end else begin
            pc   <= br_take ? br_target : pc_plus4;
            fd_q <= br_take ? '0 : '{pc4: pc_plus4, word: fetch_word};
            dx_q <= br_take ? '0 : dx_d;
            xm_q <= br_take ? '0 : xm_d;
            mw_q <= mw_d;
        end
    end

    // ---------------- observation ----------------
    assign fetch_pc = pc;
    assign wb_we    = mw_q.wb.reg_wr && (mw_q.dst != '0);
    assign wb_reg   = mw_q.dst;
    assign wb_data  = wb_val;
    assign st_we    = xm_q.mem.wr_en;
    assign st_addr  = xm_q.result;
    assign st_data  = xm_q.st_val;

endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
    import pipe5_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [XLEN-1:0]    pc,
    input logic               br_take,
    input logic [XLEN-1:0]    br_target,
    input logic               dx_wr,
    input logic               xm_wr,
    input logic               xm_rd,
    input logic               xm_st,
    input logic [REG_IDX-1:0] rs_addr,
    input logic [XLEN-1:0]    rs_data,
    input logic               wb_we,
    input logic [REG_IDX-1:0] wb_reg,
    input logic [XLEN-1:0]    wb_data,
    input logic               st_we
);

    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wb_we && !st_we && pc == '0)); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(br_take)) |-> (pc == $past(pc) + XLEN'(4))); // R2

    AST_MEM_ONE_OP: assert property (@(posedge clk) disable iff (rst)
        $onehot0({xm_rd, xm_st})); // R4

    AST_SAME_CYCLE_READ: assert property (@(posedge clk) disable iff (rst)
        (wb_we && rs_addr == wb_reg) |-> (rs_data == wb_data)); // R6

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        (rs_addr == '0) |-> (rs_data == '0)); // R7

    AST_BR_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(br_take)) |-> (pc == $past(br_target))); // R8

    AST_BR_SQUASH: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(br_take)) |-> (!dx_wr && !xm_wr)); // R8

endmodule

bind pipe5_core pipe5_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pc        (pc),
    .br_take   (br_take),
    .br_target (br_target),
    .dx_wr     (dx_q.wb.reg_wr | dx_q.mem.wr_en),
    .xm_wr     (xm_q.wb.reg_wr | xm_q.mem.wr_en),
    .xm_rd     (xm_q.mem.rd_en),
    .xm_st     (xm_q.mem.wr_en),
    .rs_addr   (rs_addr),
    .rs_data   (rs_data),
    .wb_we     (wb_we),
    .wb_reg    (wb_reg),
    .wb_data   (wb_data),
    .st_we     (st_we)
);

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NWORDS     = 32;
    localparam int RUN_CYCLES = 40;

    function automatic logic [31:0] enc_r(input int fn, input int rd, input int rs, input int rt);
        logic [31:0] w;
        w = {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
        return w;
    endfunction

    function automatic logic [31:0] enc_i(input int op, input int rt, input int rs, input int imm);
        logic [31:0] w;
        w = {6'(op), 5'(rs), 5'(rt), 16'(imm)};
        return w;
    endfunction

    function automatic logic [NWORDS*32-1:0] build_prog();
        logic [NWORDS*32-1:0] p;
        p = '0;
        p[ 0*32 +: 32] = enc_r(32, 3, 1, 2);      // r3 = 203
        p[ 1*32 +: 32] = enc_r(34, 4, 5, 6);      // r4 = -1
        p[ 2*32 +: 32] = enc_r(36, 7, 8, 9);      // r7 = 108
        p[ 3*32 +: 32] = enc_r(37, 10, 11, 12);   // r10 = 127
        p[ 4*32 +: 32] = enc_i(35, 13, 0, 8);     // r13 = mem[2] = 502
        p[ 5*32 +: 32] = enc_i(43, 14, 0, 16);    // mem[4] = 114
        p[ 6*32 +: 32] = enc_r(32, 0, 1, 2);      // write to r0
        p[ 7*32 +: 32] = enc_r(32, 19, 13, 1);    // r19 = 603 (same-cycle read)
        p[ 8*32 +: 32] = 32'h0;                   // no-op
        p[ 9*32 +: 32] = enc_r(32, 15, 0, 0);     // r15 = 0
        p[10*32 +: 32] = enc_i(35, 16, 0, 16);    // r16 = 114
        p[11*32 +: 32] = enc_r(32, 17, 3, 4);     // r17 = 202
        p[12*32 +: 32] = enc_i(4, 1, 1, 3);       // taken -> 64
        p[13*32 +: 32] = enc_r(32, 20, 1, 1);     // squashed
        p[14*32 +: 32] = enc_i(43, 1, 0, 0);      // squashed
        p[15*32 +: 32] = enc_r(32, 21, 1, 1);     // squashed
        p[16*32 +: 32] = enc_i(4, 2, 1, 5);       // not taken
        p[17*32 +: 32] = enc_r(32, 22, 2, 2);     // r22 = 204
        p[18*32 +: 32] = enc_i(43, 17, 0, 20);    // mem[5] = 202
        p[19*32 +: 32] = enc_i(35, 23, 24, -4);   // r23 = mem[30] = 530
        p[20*32 +: 32] = enc_i(4, 0, 0, -1);      // spin here
        return p;
    endfunction

    localparam logic [NWORDS*32-1:0] PROG = build_prog();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc;
    logic        wb_we;
    logic [4:0]  wb_reg;
    logic [31:0] wb_data;
    logic        st_we;
    logic [31:0] st_addr;
    logic [31:0] st_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe5_core #(
        .IMEM_WORDS (NWORDS),
        .DMEM_WORDS (64),
        .NREGS      (32),
        .REG_BASE   (100),
        .MEM_BASE   (500),
        .PROGRAM    (PROG)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .fetch_pc (fetch_pc),
        .wb_we    (wb_we),
        .wb_reg   (wb_reg),
        .wb_data  (wb_data),
        .st_we    (st_we),
        .st_addr  (st_addr),
        .st_data  (st_data)
    );

    typedef struct {
        int          due;
        logic [4:0]  idx;
        logic [31:0] val;
        string       req;
    } wb_item_t;

    typedef struct {
        int          due;
        logic [31:0] addr;
        logic [31:0] val;
        string       req;
    } st_item_t;

    wb_item_t wb_q[$];
    st_item_t st_q[$];
    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_wb(input int due, input int idx, input logic [31:0] val, input string req);
        wb_item_t it;
        it.due = due; it.idx = 5'(idx); it.val = val; it.req = req;
        wb_q.push_back(it);
    endtask

    task automatic push_st(input int due, input logic [31:0] addr, input logic [31:0] val, input string req);
        st_item_t it;
        it.due = due; it.addr = addr; it.val = val; it.req = req;
        st_q.push_back(it);
    endtask

    task automatic mon_wb(input int cyc);
        if (wb_q.size() != 0 && wb_q[0].due == cyc) begin
            wb_item_t it;
            it = wb_q.pop_front();
            chk(wb_we && wb_reg == it.idx && wb_data == it.val, it.req,
                {26'd0, wb_we, wb_reg}, {27'd1, it.idx});
            chk(wb_data == it.val, it.req, wb_data, it.val);
        end else if (wb_we) begin
            // stray write: squashed branch shadow, r0 target or no-op
            chk(1'b0, "R7/R8/R10 stray write", {27'd0, wb_reg}, 32'd0);
        end
    endtask

    task automatic mon_st(input int cyc);
        if (st_q.size() != 0 && st_q[0].due == cyc) begin
            st_item_t it;
            it = st_q.pop_front();
            chk(st_we && st_addr == it.addr, it.req, st_addr, it.addr);
            chk(st_data == it.val, it.req, st_data, it.val);
        end else if (st_we) begin
            chk(1'b0, "R8/R10 stray store", st_addr, 32'd0);
        end
    endtask

    function automatic logic [31:0] exp_pc(input int cyc);
        if (cyc <= 15)      return 32'(4 * cyc);       // sequential, R2
        else if (cyc <= 23) return 32'(4 * cyc);       // R8 target 64 lands at cycle 16, R9 keeps order
        else                return 32'd80;             // self-branch spin
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        // driver: expected results with their due cycles (fetch cycle + 4 / + 3)
        push_wb( 4,  3, 32'd203,        "R3 add");
        push_wb( 5,  4, 32'hFFFF_FFFF,  "R3 sub");
        push_wb( 6,  7, 32'd108,        "R3 and");
        push_wb( 7, 10, 32'd127,        "R3 or");
        push_wb( 8, 13, 32'd502,        "R4 load");
        push_wb(11, 19, 32'd603,        "R6 same-cycle read");
        push_wb(13, 15, 32'd0,          "R7 r0 reads zero");
        push_wb(14, 16, 32'd114,        "R4 load after store");
        push_wb(15, 17, 32'd202,        "R3 add of results");
        push_wb(21, 22, 32'd204,        "R9 fall-through");
        push_wb(23, 23, 32'd530,        "R5 negative offset");
        push_st( 8, 32'd16, 32'd114,    "R4 store");
        push_st(21, 32'd20, 32'd202,    "R4 store after branch");

        repeat (3) @(negedge clk);
        #1;
        chk(fetch_pc == 32'd0, "R1 reset pc", fetch_pc, 32'd0);
        chk(!wb_we && !st_we, "R1 reset quiet", {30'd0, wb_we, st_we}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int cyc = 0; cyc <= RUN_CYCLES; cyc++) begin
            #1;
            if (cyc < 4) begin
                chk(!wb_we && !st_we, "R1 fill quiet", {30'd0, wb_we, st_we}, 32'd0);
            end
            if (cyc <= 24 || cyc == RUN_CYCLES) begin
                chk(fetch_pc == exp_pc(cyc), (cyc == 16) ? "R8 branch target" :
                    (cyc == 20) ? "R9 not taken" : "R2 pc step", fetch_pc, exp_pc(cyc));
            end
            mon_wb(cyc);
            mon_st(cyc);
            @(negedge clk);
        end

        chk(wb_q.size() == 0, "R3 missing writeback", 32'(wb_q.size()), 32'd0);
        chk(st_q.size() == 0, "R4 missing store", 32'(st_q.size()), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule